// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits between the one-bit serial front end of a NOR flash and its array controller, and decides whether each instruction that would change stored data or settings may run. It oversamples the serial clock, chip select and serial input on the system clock. It collects the opcode, a 24-bit address sent most significant bit first and one data byte, and counts the serial clock rising edges in each frame. When chip select rises it either sends the instruction to the array controller as a one-cycle execute strobe, or drops it without any sign.

Five conditions must all hold before an instruction is admitted. The write-enable latch must be set. The power-up lockout timer must have expired. The frame must be a whole number of bytes of at least the instruction's length. No earlier job may still be running. The target 64-Kbyte sector must be unlocked. The block holds one lock bit per sector, selected by address bits 23:16. An active-low protect pin freezes the protection settings. The latch clears by itself when an admitted job completes.

Top module: `wpg_gate`

## Requirements
- R1: Opcode 06h in a whole-byte frame sets the latch `wel`. The modifying opcodes are 01h (status write), 02h (page program), 20h (subsector erase), D8h (sector erase), C7h (bulk erase) and E5h (lock write). Each is refused when the latch is clear at chip-select rise.
- R2: After `por_n` is released, `wel`, `busy`, `exec_stb` and every lock bit read 0. Opcode 04h in a whole-byte frame clears `wel`.
- R3: `wel` returns to 0 in the clock after `op_done` is seen high while `busy` is high. An accepted lock write clears `wel` as soon as it is applied.
- R4: A modifying instruction runs only if the count of serial clock rising edges under chip select is a multiple of 8 and at least its minimum length. The minimums are 8 for C7h, 16 for 01h, 32 for 20h and D8h, and 40 for 02h and E5h. A discarded instruction leaves `wel` unchanged.
- R5: For `PUW_CYC` system clocks after reset every instruction is ignored, 06h included.
- R6: Lock write E5h is the opcode, then a 24-bit address, then a data byte. Bit 0 of the data byte becomes the lock bit of sector address[23:16]. A 02h, 20h or D8h aimed at a locked sector is refused, and `wel` is left set.
- R7: An admitted 01h, 02h, 20h, D8h or C7h gives a one-clock `exec_stb` that carries the opcode and the 24-bit address, and raises `busy`.
- R8: While `busy` is high every instruction is refused, 04h included.
- R9: While `wp_n` is low, 01h and E5h are refused.
- R10: C7h is refused while any lock bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk | input | 1 | Serial clock, oversampled |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on the rising edge of sclk |
| wp_n | input | 1 | Active-low hardware freeze of the protection settings |
| op_done | input | 1 | Array controller reports the running job is finished |
| exec_stb | output | 1 | One-cycle strobe for an admitted instruction |
| exec_op | output | 8 | Opcode sent with the strobe |
| exec_addr | output | 24 | Address sent with the strobe |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | A job is running in the array controller |
| lock_bits | output | NSECT | One lock bit per sector |

## Verification
A wrong bit counter or a misplaced shift boundary shows up on the first frame after the error. A frame of 31 or 33 clocks gets through, or a good frame carries a shifted address on `exec_addr`. A stale latch or busy flag shows up within one frame, as a strobe where none should appear, or as `wel` still set one clock after `op_done`. A wrong lock bit shows up directly on `lock_bits` and on the next program or erase to that sector. The lockout timer is checked by sending a write enable before the timer expires.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  localparam int FL_ADDR_W = 24;
  localparam int BITCNT_W  = 16;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SSE  = 8'h20;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_WRLK = 8'hE5;

  // instruction needs the write-enable latch
  function automatic logic is_modify(input logic [7:0] op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SSE) ||
           (op == OP_SE) || (op == OP_BE) || (op == OP_WRLK);
  endfunction

  // instruction is handed to the array controller
  function automatic logic starts_job(input logic [7:0] op);
    return is_modify(op) && (op != OP_WRLK);
  endfunction

  // instruction targets one sector and obeys its lock
  function automatic logic hits_sector(input logic [7:0] op);
    return (op == OP_PP) || (op == OP_SSE) || (op == OP_SE);
  endfunction

  // instruction changes protection settings
  function automatic logic guards_prot(input logic [7:0] op);
    return (op == OP_WRSR) || (op == OP_WRLK);
  endfunction

  // shortest legal frame in bits, 0 for an unknown opcode
  function automatic logic [BITCNT_W-1:0] min_bits(input logic [7:0] op);
    case (op)
      OP_WREN, OP_WRDI, OP_BE: return BITCNT_W'(8);
      OP_WRSR:                 return BITCNT_W'(16);
      OP_SSE, OP_SE:           return BITCNT_W'(8 + FL_ADDR_W);
      OP_PP, OP_WRLK:          return BITCNT_W'(16 + FL_ADDR_W);
      default:                 return '0;
    endcase
  endfunction

  // whole bytes and long enough
  function automatic logic frame_ok(input logic [7:0] op, input logic [BITCNT_W-1:0] n);
    return (min_bits(op) != '0) && (n[2:0] == 3'd0) && (n >= min_bits(op));
  endfunction

endpackage

// File: rtl/wpg_frame.sv
module wpg_frame
  import wpg_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 si,
  output logic                 frm_end,
  output logic [7:0]           frm_op,
  output logic [FL_ADDR_W-1:0] frm_addr,
  output logic [7:0]           frm_dat,
  output logic [BITCNT_W-1:0]  frm_bits
);
  localparam int SYNC_N  = 3;
  localparam int ADDR_LO = 8;
  localparam int DAT_LO  = 8 + FL_ADDR_W;
  localparam int DAT_HI  = 16 + FL_ADDR_W;

  logic [SYNC_N-1:0] sck_sr, csn_sr, si_sr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sck_sr <= '0;
      csn_sr <= '1;
      si_sr  <= '0;
    end else begin
      sck_sr <= {sck_sr[SYNC_N-2:0], sclk};
      csn_sr <= {csn_sr[SYNC_N-2:0], cs_n};
      si_sr  <= {si_sr[SYNC_N-2:0], si};
    end
  end

  logic sck_rise, cs_fall, cs_low, si_s;
  assign sck_rise = sck_sr[SYNC_N-2] & ~sck_sr[SYNC_N-1];
  assign cs_fall  = ~csn_sr[SYNC_N-2] & csn_sr[SYNC_N-1];
  assign cs_low   = ~csn_sr[SYNC_N-2];
  assign si_s     = si_sr[SYNC_N-2];
  assign frm_end  = csn_sr[SYNC_N-2] & ~csn_sr[SYNC_N-1];

  logic bit_take;
  assign bit_take = sck_rise & cs_low & ~cs_fall;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      frm_bits <= '0;
      frm_op   <= '0;
      frm_addr <= '0;
      frm_dat  <= '0;
    end else if (cs_fall) begin
      frm_bits <= '0;
      frm_op   <= '0;
      frm_addr <= '0;
      frm_dat  <= '0;
    end else if (bit_take) begin
      if (frm_bits != '1) frm_bits <= frm_bits + 1'b1;
      if (frm_bits < BITCNT_W'(ADDR_LO))
        frm_op <= {frm_op[6:0], si_s};
      else if (frm_bits < BITCNT_W'(DAT_LO))
        frm_addr <= {frm_addr[FL_ADDR_W-2:0], si_s};
      else if (frm_bits < BITCNT_W'(DAT_HI))
        frm_dat <= {frm_dat[6:0], si_s};
    end
  end

  AST_BITS_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    (!cs_low && !frm_end) |=> $stable(frm_bits)); // R4

endmodule

// File: rtl/wpg_lockout.sv
module wpg_lockout #(
  parameter int PUW_CYC = 256
) (
  input  logic clk,
  input  logic por_n,
  output logic ready
);
  localparam int CNT_W = $clog2(PUW_CYC + 1);

  logic [CNT_W-1:0] cnt;

  assign ready = (cnt == CNT_W'(PUW_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt <= '0;
    else if (!ready) cnt <= cnt + 1'b1;
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready); // R5

endmodule

// File: rtl/wpg_locks.sv
module wpg_locks #(
  parameter int NSECT = 256
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     lk_we,
  input  logic [$clog2(NSECT)-1:0] lk_sel,
  input  logic                     lk_val,
  output logic [NSECT-1:0]         lk_bits
);
  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lk_bits[g] <= 1'b0;
      else if (lk_we && (lk_sel == g)) lk_bits[g] <= lk_val;
    end
  end

  AST_ONE_LOCK_CHANGE: assert property (@(posedge clk) disable iff (!por_n)
    !lk_we |=> $stable(lk_bits)); // R6

endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
  import wpg_pkg::*;
#(
  parameter int PUW_CYC = 256,
  parameter int NSECT   = 256
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 si,
  input  logic                 wp_n,
  input  logic                 op_done,
  output logic                 exec_stb,
  output logic [7:0]           exec_op,
  output logic [FL_ADDR_W-1:0] exec_addr,
  output logic                 wel,
  output logic                 busy,
  output logic [NSECT-1:0]     lock_bits
);
  localparam int SECT_W = $clog2(NSECT);

  logic                 frm_end;
  logic [7:0]           frm_op;
  logic [FL_ADDR_W-1:0] frm_addr;
  logic [7:0]           frm_dat;
  logic [BITCNT_W-1:0]  frm_bits;
  logic                 ready;

  wpg_frame u_frame (
    .clk(clk), .por_n(por_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .frm_end(frm_end), .frm_op(frm_op), .frm_addr(frm_addr),
    .frm_dat(frm_dat), .frm_bits(frm_bits)
  );

  wpg_lockout #(.PUW_CYC(PUW_CYC)) u_lockout (
    .clk(clk), .por_n(por_n), .ready(ready)
  );

  logic [1:0] wp_sr;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wp_sr <= 2'b11;
    else        wp_sr <= {wp_sr[0], wp_n};
  end

  // named decision events
  logic [SECT_W-1:0] tgt_sect;
  logic cmd_ok, sect_lk, prot_frozen, grant, grant_job, grant_lock;
  logic set_wel, clr_wel_cmd, job_finish;

  assign tgt_sect    = frm_addr[FL_ADDR_W-1 -: SECT_W];
  assign sect_lk     = lock_bits[tgt_sect];
  assign prot_frozen = ~wp_sr[1];
  assign cmd_ok      = frm_end & ready & ~busy & frame_ok(frm_op, frm_bits);
  assign grant       = cmd_ok & is_modify(frm_op) & wel
                     & ~(guards_prot(frm_op) & prot_frozen)
                     & ~(hits_sector(frm_op) & sect_lk)
                     & ~((frm_op == OP_BE) & (|lock_bits));
  assign grant_job   = grant & starts_job(frm_op);
  assign grant_lock  = grant & (frm_op == OP_WRLK);
  assign set_wel     = cmd_ok & (frm_op == OP_WREN);
  assign clr_wel_cmd = cmd_ok & (frm_op == OP_WRDI);
  assign job_finish  = busy & op_done;

  wpg_locks #(.NSECT(NSECT)) u_locks (
    .clk(clk), .por_n(por_n), .lk_we(grant_lock), .lk_sel(tgt_sect),
    .lk_val(frm_dat[0]), .lk_bits(lock_bits)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wel       <= 1'b0;
      busy      <= 1'b0;
      exec_stb  <= 1'b0;
      exec_op   <= '0;
      exec_addr <= '0;
    end else begin
      exec_stb <= 1'b0;
      if (job_finish) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
      if (set_wel)                  wel <= 1'b1;
      if (clr_wel_cmd || grant_lock) wel <= 1'b0;
      if (grant_job) begin
        exec_stb  <= 1'b1;
        exec_op   <= frm_op;
        exec_addr <= frm_addr;
        busy      <= 1'b1;
      end
    end
  end

  AST_STB_NEEDS_WEL: assert property (@(posedge clk) disable iff (!por_n)
    exec_stb |-> $past(wel)); // R1
  AST_WEL_CLR_DONE: assert property (@(posedge clk) disable iff (!por_n)
    (busy && op_done) |=> !wel); // R3
  AST_STB_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!por_n)
    exec_stb |-> ($past(frm_bits[2:0]) == 3'd0)); // R4
  AST_STB_AFTER_LOCKOUT: assert property (@(posedge clk) disable iff (!por_n)
    exec_stb |-> $past(ready)); // R5
  AST_STB_UNLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (exec_stb && hits_sector(exec_op)) |-> !lock_bits[exec_addr[FL_ADDR_W-1 -: SECT_W]]); // R6
  AST_STB_RAISES_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    exec_stb |-> busy); // R7
  AST_NO_STB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    exec_stb |-> !$past(busy)); // R8
  AST_BE_ALL_UNLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (exec_stb && exec_op == OP_BE) |-> (lock_bits == '0)); // R10

endmodule

// File: tb/tb_wpg_gate.sv
module tb_wpg_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PUW        = 150;
  localparam int NS         = 256;

  logic clk = 1'b0, por_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic wp_n = 1'b1, op_done = 1'b0;
  logic exec_stb, wel, busy;
  logic [7:0] exec_op;
  logic [23:0] exec_addr;
  logic [NS-1:0] lock_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpg_gate #(.PUW_CYC(PUW), .NSECT(NS)) dut (
    .clk(clk), .por_n(por_n), .sclk(sclk), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .op_done(op_done), .exec_stb(exec_stb), .exec_op(exec_op),
    .exec_addr(exec_addr), .wel(wel), .busy(busy), .lock_bits(lock_bits)
  );

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [7:0]  last_op = '0;
  logic [23:0] last_addr = '0;

  always @(posedge clk) if (exec_stb) begin
    stb_cnt   <= stb_cnt + 1;
    last_op   <= exec_op;
    last_addr <= exec_addr;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] op, input logic [23:0] a,
                       input logic [7:0] d, input int n);
    logic [39:0] v;
    v = {op, a, d};
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = (i < 40) ? v[39-i] : 1'b0;
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_job();
    op_done = 1'b1; @(negedge clk);
    op_done = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int s0;
    bit exp;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(wel == 0 && busy == 0 && exec_stb == 0, "R2", "reset flags", {wel, busy, exec_stb}, 0);
    check(lock_bits == '0, "R2", "reset locks", lock_bits[31:0], 0);

    // R5 write enable inside the lockout window is ignored
    frame(8'h06, 24'h0, 8'h0, 8);
    check(wel == 0, "R5", "wel after early enable", wel, 0);
    repeat (PUW) @(negedge clk);

    frame(8'h06, 24'h0, 8'h0, 8);
    check(wel == 1, "R1", "wel after enable", wel, 1);
    frame(8'h04, 24'h0, 8'h0, 8);
    check(wel == 0, "R2", "wel after disable", wel, 0);

    // R1 page program without write enable
    s0 = stb_cnt;
    frame(8'h02, 24'h010203, 8'hAA, 48);
    check(stb_cnt == s0, "R1", "strobe without latch", stb_cnt - s0, 0);

    // R7 accepted page program
    frame(8'h06, 24'h0, 8'h0, 8);
    s0 = stb_cnt;
    frame(8'h02, 24'h123456, 8'h5A, 48);
    check(stb_cnt == s0 + 1, "R7", "program strobe count", stb_cnt - s0, 1);
    check(last_op == 8'h02, "R7", "strobe opcode", last_op, 8'h02);
    check(last_addr == 24'h123456, "R7", "strobe address", last_addr, 24'h123456);
    check(busy == 1, "R7", "busy after strobe", busy, 1);
    // R8 disable while busy is refused
    frame(8'h04, 24'h0, 8'h0, 8);
    check(wel == 1, "R8", "wel after busy disable", wel, 1);
    finish_job();
    check(busy == 0 && wel == 0, "R3", "flags after done", {busy, wel}, 0);

    // R4 bit-count sweep on sector erase, includes 31
    for (int n = 30; n <= 41; n++) begin
      frame(8'h06, 24'h0, 8'h0, 8);
      s0 = stb_cnt;
      frame(8'hD8, 24'h050000, 8'h00, n);
      exp = (n % 8 == 0) && (n >= 32);
      check((stb_cnt - s0) == int'(exp), "R4", $sformatf("erase strobe n=%0d", n), stb_cnt - s0, exp);
      if (exp) begin
        finish_job();
        check(wel == 0, "R3", $sformatf("wel after erase n=%0d", n), wel, 0);
      end else begin
        check(wel == 1, "R4", $sformatf("wel kept n=%0d", n), wel, 1);
        frame(8'h04, 24'h0, 8'h0, 8);
      end
    end

    // R9 lock write frozen by pin
    wp_n = 1'b0;
    frame(8'h06, 24'h0, 8'h0, 8);
    frame(8'hE5, 24'h120000, 8'h01, 40);
    check(lock_bits[8'h12] == 0, "R9", "lock under freeze", lock_bits[8'h12], 0);
    check(wel == 1, "R9", "wel under freeze", wel, 1);
    wp_n = 1'b1;
    frame(8'hE5, 24'h120000, 8'h01, 40);
    check(lock_bits[8'h12] == 1 && lock_bits[8'h13] == 0, "R6", "lock set", lock_bits[8'h13:8'h12], 1);
    check(wel == 0, "R3", "wel after lock write", wel, 0);

    // R6 program to locked sector
    frame(8'h06, 24'h0, 8'h0, 8);
    s0 = stb_cnt;
    frame(8'h02, 24'h12ABCD, 8'h11, 40);
    check(stb_cnt == s0, "R6", "locked program", stb_cnt - s0, 0);
    check(wel == 1, "R6", "wel after locked program", wel, 1);
    frame(8'h02, 24'h130010, 8'h11, 40);
    check(stb_cnt == s0 + 1 && last_addr == 24'h130010, "R6", "neighbour program", last_addr, 24'h130010);
    finish_job();

    // R10 bulk erase refused with a lock set
    frame(8'h06, 24'h0, 8'h0, 8);
    s0 = stb_cnt;
    frame(8'hC7, 24'h0, 8'h0, 8);
    check(stb_cnt == s0, "R10", "bulk erase locked", stb_cnt - s0, 0);
    frame(8'hE5, 24'h120000, 8'h00, 40);
    check(lock_bits == '0, "R6", "lock cleared", lock_bits[31:0], 0);
    frame(8'h06, 24'h0, 8'h0, 8);
    frame(8'hC7, 24'h0, 8'h0, 8);
    check(stb_cnt == s0 + 1 && last_op == 8'hC7, "R10", "bulk erase unlocked", last_op, 8'hC7);
    finish_job();

    // R9 status write and the pin
    wp_n = 1'b0;
    frame(8'h06, 24'h0, 8'h0, 8);
    s0 = stb_cnt;
    frame(8'h01, 24'h0, 8'h0, 16);
    check(stb_cnt == s0, "R9", "status write frozen", stb_cnt - s0, 0);
    wp_n = 1'b1;
    frame(8'h01, 24'h0, 8'h0, 16);
    check(stb_cnt == s0 + 1 && last_op == 8'h01, "R9", "status write free", last_op, 8'h01);
    finish_job();
    check(wel == 0, "R3", "wel after status write", wel, 0);

    summary();
  end
endmodule